// File: doc/BRIEF.md
# Power-Fail Reset and Write-Protect Supervisor

This block watches two digitized supply comparators and turns them into three control outputs for a battery-backed memory subsystem: a processor reset, modelled as an open-drain pull-down, a memory write-protect, and a select line that chooses the battery or the main supply as the memory's power source. The first comparator reports that the supply is above the write-protect trip level. The second reports that it is above the lower battery-switchover level. The analog comparators and the power switch sit outside this block.

When the supply falls below the trip level, write protection and the reset pull-down take effect as soon as the comparator input has passed through the synchronizer, whatever the timers hold. On power-up two hold timers run on a slow tick input, for example one pulse per millisecond. Write protection ends after a recovery count. The reset is released after a longer count. A power-good flag goes to the battery monitor at the moment the recovery count completes. A supply dip during either hold period restarts both counts from zero. Battery selection depends only on the switchover comparator and does not depend on the trip level.

Top module: `supply_guard`

## Requirements
- R1: While `rst_n` is low and just after it, `wr_protect`=1, `rst_pull_low`=1, `pwr_good`=0 and `bat_select`=1, because both comparators are taken as low.
- R2: A change on `sup_trip_ok` or `sup_sw_ok` reaches the outputs after exactly SYNC_STAGES rising clock edges, and has no effect after fewer edges (default 2).
- R3: When the synchronized `sup_trip_ok` is low, `wr_protect`=1, `pwr_good`=0 and `rst_pull_low`=1, whatever the timer state. A value of 1 on `rst_pull_low` means the reset line is driven low. A value of 0 means the line is released.
- R4: `wr_protect` falls and `pwr_good` rises in the cycle after the clock edge that samples the REC_TICKS-th `tick` high while the synchronized trip input is high. Until then both keep their protected values.
- R5: `rst_pull_low` falls in the cycle after the clock edge that samples the RST_TICKS-th such tick. RST_TICKS must be greater than REC_TICKS, and this is checked at elaboration, so the reset is never released while writes are still blocked.
- R6: A low on the synchronized trip input during either hold period clears both counts. After the supply returns, the full REC_TICKS and RST_TICKS are needed again.
- R7: `bat_select` is 1 while the synchronized `sup_sw_ok` is 0 and 0 while it is 1, for either state of the trip input.
- R8: Ticks that arrive while the synchronized trip input is low are ignored and add nothing to either count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse for the hold timers |
| sup_trip_ok | input | 1 | Comparator: supply above write-protect trip level |
| sup_sw_ok | input | 1 | Comparator: supply above battery-switchover level |
| rst_pull_low | output | 1 | 1 = drive the open-drain reset line low, 0 = release it |
| wr_protect | output | 1 | 1 = memory writes blocked |
| bat_select | output | 1 | 1 = battery powers the memory, 0 = main supply |
| pwr_good | output | 1 | Recovery time elapsed with the supply valid, for the battery monitor |

## Verification
A comparator change shows on the outputs after two clock edges, the synchronizer depth. The bench therefore drives each input on a falling edge and samples one falling edge later, where the change must not yet be visible, and again two falling edges later, where it must be. A tick counts at the rising edge that samples it high, and the outputs it releases are combinational from the updated count. The bench pulses each tick across one rising edge and samples at the next falling edge. It checks that the release is absent after count minus one ticks and present after the last one. The checker repeats the timer check with its own tick counter, which it clears while the supply is low.

// File: rtl/sg_pkg.sv
package sg_pkg;

   // Supervisor phase, derived from the synchronized trip input and the two timers
   typedef enum logic [1:0] {
      SG_DOWN    = 2'd0,   // supply below trip level
      SG_RECOVER = 2'd1,   // supply valid, recovery count running
      SG_HOLD    = 2'd2,   // writes allowed, reset still held
      SG_RUN     = 2'd3    // normal operation
   } sg_phase_e;

   // Bit positions inside the synchronizer bundle
   localparam int unsigned SG_TRIP_BIT = 0;
   localparam int unsigned SG_SW_BIT   = 1;
   localparam int unsigned SG_NUM_CMP  = 2;

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("sg_sync: WIDTH must be at least 1");
      end

      if (STAGES == 0) begin : g_bypass
         assign d_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] stage_q [STAGES];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[0] <= '0;
            end else begin
               stage_q[0] <= d_in;
            end
         end

         for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  stage_q[s] <= '0;
               end else begin
                  stage_q[s] <= stage_q[s-1];
               end
            end
         end

         assign d_out = stage_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/sg_hold_timer.sv
module sg_hold_timer #(
   parameter int unsigned LIMIT = 125,
   localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,     // clear while low
   input  logic tick,
   output logic done
);

   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("sg_hold_timer: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != LIM_V)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done = (cnt_q == LIM_V);

endmodule

// File: rtl/supply_guard.sv
module supply_guard #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned REC_TICKS   = 125,
   parameter int unsigned RST_TICKS   = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic sup_trip_ok,
   input  logic sup_sw_ok,
   output logic rst_pull_low,
   output logic wr_protect,
   output logic bat_select,
   output logic pwr_good
);
   import sg_pkg::*;

   logic [SG_NUM_CMP-1:0] cmp_raw;
   logic [SG_NUM_CMP-1:0] cmp_s;
   logic                  trip_s;
   logic                  sw_s;
   logic                  rec_done;
   logic                  rst_done;
   sg_phase_e             phase;

   generate
      if (RST_TICKS <= REC_TICKS) begin : g_bad_order
         $error("supply_guard: RST_TICKS must exceed REC_TICKS");
      end
   endgenerate

   assign cmp_raw[SG_TRIP_BIT] = sup_trip_ok;
   assign cmp_raw[SG_SW_BIT]   = sup_sw_ok;

   sg_sync #(.WIDTH(SG_NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (cmp_raw),
      .d_out (cmp_s)
   );

   assign trip_s = cmp_s[SG_TRIP_BIT];
   assign sw_s   = cmp_s[SG_SW_BIT];

   sg_hold_timer #(.LIMIT(REC_TICKS)) u_rec_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (trip_s),
      .tick  (tick),
      .done  (rec_done)
   );

   sg_hold_timer #(.LIMIT(RST_TICKS)) u_rst_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (trip_s),
      .tick  (tick),
      .done  (rst_done)
   );

   always_comb begin
      if (!trip_s)        phase = SG_DOWN;
      else if (!rec_done) phase = SG_RECOVER;
      else if (!rst_done) phase = SG_HOLD;
      else                phase = SG_RUN;
   end

   assign wr_protect   = (phase == SG_DOWN) || (phase == SG_RECOVER);
   assign pwr_good     = !wr_protect;
   assign rst_pull_low = (phase != SG_RUN);
   assign bat_select   = !sw_s;

endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
   parameter int unsigned REC_TICKS = 125,
   parameter int unsigned RST_TICKS = 200,
   localparam int unsigned CW = $clog2(RST_TICKS + 2)
) (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic trip_s,
   input logic rst_pull_low,
   input logic wr_protect,
   input logic pwr_good
);

   localparam logic [CW-1:0] SAT = CW'(RST_TICKS + 1);

   logic [CW-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     seen_q <= '0;
      else if (!trip_s)               seen_q <= '0;
      else if (tick && seen_q != SAT) seen_q <= seen_q + 1'b1;
   end

   // R3: supply low forces protection and reset
   p_low_forces_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !trip_s |-> (wr_protect && rst_pull_low && !pwr_good));

   // R4: write protect ends exactly at the recovery count
   p_wp_release_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_protect) |-> (seen_q == CW'(REC_TICKS)));

   // R5: reset is released exactly at the reset count
   p_rst_release_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_pull_low) |-> (seen_q == CW'(RST_TICKS)));

   // R5: reset never released while writes are blocked
   p_rst_after_wp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rst_pull_low |-> !wr_protect);

   // R4: power-good only when not protected
   p_pgood_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_good |-> !wr_protect);

   // R6: a dip drops power-good in the same cycle
   p_dip_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(trip_s) |-> (!pwr_good && rst_pull_low));

endmodule

bind supply_guard sg_checker #(
   .REC_TICKS (REC_TICKS),
   .RST_TICKS (RST_TICKS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .trip_s       (trip_s),
   .rst_pull_low (rst_pull_low),
   .wr_protect   (wr_protect),
   .pwr_good     (pwr_good)
);

// File: tb/supply_guard_tb.sv
module supply_guard_tb;

   localparam time CLK_PERIOD = 10ns;
   localparam int  REC = 5;
   localparam int  RST = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic trip_ok = 1'b0;
   logic sw_ok = 1'b0;
   logic rst_pull_low, wr_protect, bat_select, pwr_good;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   supply_guard #(.SYNC_STAGES(2), .REC_TICKS(REC), .RST_TICKS(RST)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .sup_trip_ok  (trip_ok),
      .sup_sw_ok    (sw_ok),
      .rst_pull_low (rst_pull_low),
      .wr_protect   (wr_protect),
      .bat_select   (bat_select),
      .pwr_good     (pwr_good)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic check_all(input string req, input logic rp, input logic wp, input logic pg);
      check(req, "rst_pull_low", rst_pull_low, rp);
      check(req, "wr_protect", wr_protect, wp);
      check(req, "pwr_good", pwr_good, pg);
   endtask

   task automatic pulse_ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   endtask

   task automatic set_trip(input logic v);
      @(negedge clk) trip_ok = v;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      #(CLK_PERIOD*3);
      @(negedge clk);
      check_all("R1", 1'b1, 1'b1, 1'b0);
      check("R1", "bat_select", bat_select, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_sync_bat();
      @(negedge clk) sw_ok = 1'b1;
      @(negedge clk);
      check("R2", "bat_select after one edge", bat_select, 1'b1);
      @(negedge clk);
      check("R2", "bat_select after two edges", bat_select, 1'b0);
      check("R7", "bat_select with trip low", bat_select, 1'b0);
      @(negedge clk) sw_ok = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7", "bat_select sw low", bat_select, 1'b1);
   endtask

   task automatic t_powerup();
      @(negedge clk) sw_ok = 1'b1;
      set_trip(1'b1);
      check_all("R3", 1'b1, 1'b1, 1'b0);
      pulse_ticks(REC - 1);
      check_all("R4", 1'b1, 1'b1, 1'b0);
      pulse_ticks(1);
      check_all("R4", 1'b1, 1'b0, 1'b1);
      pulse_ticks(RST - REC - 1);
      check("R5", "reset held before count", rst_pull_low, 1'b1);
      pulse_ticks(1);
      check_all("R5", 1'b0, 1'b0, 1'b1);
      check("R7", "bat_select trip high", bat_select, 1'b0);
   endtask

   task automatic t_fail_from_run();
      @(negedge clk) trip_ok = 1'b0;
      @(negedge clk);
      check("R2", "wr_protect after one edge", wr_protect, 1'b0);
      @(negedge clk);
      check_all("R3", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_ignore_low_ticks();
      pulse_ticks(RST + 2);
      check_all("R8", 1'b1, 1'b1, 1'b0);
      set_trip(1'b1);
      pulse_ticks(REC - 1);
      check("R8", "no carried ticks", wr_protect, 1'b1);
      pulse_ticks(1);
      check("R8", "release after full count", wr_protect, 1'b0);
   endtask

   task automatic t_dip();
      // currently in hold phase with REC ticks counted
      pulse_ticks(1);
      set_trip(1'b0);
      check_all("R6", 1'b1, 1'b1, 1'b0);
      set_trip(1'b1);
      pulse_ticks(REC - 1);
      check("R6", "recovery restarted", wr_protect, 1'b1);
      pulse_ticks(1);
      check("R6", "recovery after restart", wr_protect, 1'b0);
      pulse_ticks(RST - REC - 1);
      check("R6", "reset restarted", rst_pull_low, 1'b1);
      pulse_ticks(1);
      check("R6", "reset after restart", rst_pull_low, 1'b0);
      @(negedge clk) sw_ok = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R7", "bat_select trip high sw low", bat_select, 1'b1);
      check("R7", "reset unaffected by sw", rst_pull_low, 1'b0);
   endtask

   initial begin
      #(CLK_PERIOD*20000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         report();
      end
   end

   initial begin
      t_reset();
      t_sync_bat();
      t_powerup();
      t_fail_from_run();
      t_ignore_low_ticks();
      t_dip();
      finished = 1'b1;
      report();
   end

endmodule